// File: doc/BRIEF.md
# Z-Order Scan Address Generator with Boundary-Point Hand-Off

This block produces the read address sequence for a square pixel array of 2^N by 2^N pixels and keeps an adaptive one-boundary quantizer well seeded while it reads. A `start_i` pulse begins a frame. The block then presents one pixel address per clock for 2^(2N) consecutive cycles. The order is either a hierarchical Z order or plain row-major order, chosen by `mode_i` when the frame starts.

In Z order, successive quadrants of a tree level can begin far from the pixel read just before them. An adaptive quantizer that simply carried its boundary point forward would then start each new quadrant with a value from an unrelated region of the image. To avoid that, the block keeps two saved boundary points per tree level. Each is copied from the quantizer's `bp_i` while a chosen pixel is read. When the scan enters quadrant 1, 2 or 3 of any level, the block raises `bp_load_o` and drives `bp_val_o` with the value saved at the pixel physically next to the new quadrant's first pixel. It does this in the same cycle that the first pixel's address is presented.

The address stream has valid and last markers but no ready input. The consumer must take one address per clock while `addr_valid_o` is high, because back-pressure is not supported. Quadrant numbering inside a level uses a two-bit digit: bit 0 selects the lower half (row) and bit 1 selects the right half (column).

Top module: `zscan_bp_handoff`

## Requirements
- R1: While reset is held and afterwards until a frame is started, `addr_valid_o`, `addr_last_o` and `bp_load_o` are low.
- R2: A `start_i` sampled high while idle makes pixel 0 appear in the next cycle. The frame is exactly 2^(2N) consecutive valid cycles, with `addr_last_o` high only on the final one, followed by at least one idle cycle.
- R3: A `start_i` pulse during a frame is ignored. The running frame keeps its order and its length.
- R4: In Z mode (`mode_i`=0), pixel index i drives row bit j from index bit 2j and column bit j from index bit 2j+1.
- R5: In raster mode (`mode_i`=1), pixel index i gives row = i / 2^N and column = i mod 2^N.
- R6: `mode_i` is sampled only when a frame starts. Changes during a frame do not alter that frame's addresses.
- R7: For each level, the value on `bp_i` is saved in the cycle the capture pixel is presented. Slot A is saved at the bottom-left pixel of quadrants 0 and 2. Slot B is saved at the top-right pixel of quadrant 0.
- R8: On the first pixel of a level's quadrant 1 (lower-left), `bp_load_o` is high that cycle and `bp_val_o` equals the `bp_i` value saved at the pixel directly above.
- R9: On the first pixel of quadrant 2 (upper-right), the restored value is the one saved at the pixel directly to the left.
- R10: On the first pixel of quadrant 3, the restored value is the one saved at the pixel directly above, which is the bottom-left pixel of quadrant 2.
- R11: When quadrants of several levels begin at once, the largest level's rule applies. The first pixel of a frame restores nothing, so every other Z-mode pixel asserts `bp_load_o`.
- R12: In raster mode, `bp_load_o` stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame when idle |
| mode_i | input | 1 | Scan order at frame start: 0 = Z order, 1 = raster |
| bp_i | input | BP_W | Quantizer's boundary point in the current pixel cycle |
| addr_valid_o | output | 1 | Address presented this cycle |
| addr_last_o | output | 1 | Final pixel of the frame |
| row_o | output | SIDE_LOG2 | Row address |
| col_o | output | SIDE_LOG2 | Column address |
| bp_load_o | output | 1 | Quantizer must replace its boundary point this cycle |
| bp_val_o | output | BP_W | Boundary point to load |

## Verification
The bench records the `bp_i` value it drives for every pixel coordinate. For each Z-mode pixel, it predicts the restored value from the geometric neighbour (above or to the left) chosen by the lowest nonzero quadrant digit. A design that captured a cycle late, took slot A where B was needed, or let a small level override a large one would therefore restore a value from the wrong pixel. The bench flips `mode_i` and pulses `start_i` in the middle of a frame, where a design that resampled either would change order or restart the frame. It also holds `start_i` high across a frame end, where a design lacking the idle gap, or one that loaded on pixel 0 or in raster mode, would show a valid or load flag at the wrong cycle.

// File: rtl/zscan_pkg.sv
`timescale 1ns/1ps
package zscan_pkg;

  typedef enum logic {
    SCAN_Z      = 1'b0,
    SCAN_RASTER = 1'b1
  } scan_mode_e;

  // Vector with every second bit set below nbits, starting at bit phase.
  function automatic logic [63:0] alt_bits(input int nbits, input int phase);
    logic [63:0] v;
    v = '0;
    for (int i = phase; i < nbits; i += 2) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/zscan_seq.sv
`timescale 1ns/1ps
module zscan_seq import zscan_pkg::*; #(
  parameter int SIDE_LOG2 = 3,
  localparam int CW = 2 * SIDE_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o,
  output scan_mode_e    mode_o
);

  logic          busy_q;
  logic [CW-1:0] idx_q;
  scan_mode_e    mode_q;
  logic          at_end;

  assign at_end = &idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mode_q <= SCAN_Z;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        mode_q <= scan_mode_e'(mode_i);
      end
    end else if (at_end) begin
      busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && at_end;
  assign idx_o  = idx_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/zscan_addr_map.sv
`timescale 1ns/1ps
module zscan_addr_map import zscan_pkg::*; #(
  parameter int SIDE_LOG2 = 3,
  localparam int CW = 2 * SIDE_LOG2
) (
  input  logic [CW-1:0]        idx_i,
  input  scan_mode_e           mode_i,
  output logic [SIDE_LOG2-1:0] row_o,
  output logic [SIDE_LOG2-1:0] col_o
);

  logic [SIDE_LOG2-1:0] z_row, z_col;

  // De-interleave: even index bits to the row, odd bits to the column.
  for (genvar j = 0; j < SIDE_LOG2; j++) begin : g_bit
    assign z_row[j] = idx_i[2*j];
    assign z_col[j] = idx_i[2*j+1];
  end

  always_comb begin
    if (mode_i == SCAN_RASTER) begin
      row_o = idx_i[CW-1:SIDE_LOG2];
      col_o = idx_i[SIDE_LOG2-1:0];
    end else begin
      row_o = z_row;
      col_o = z_col;
    end
  end

endmodule

// File: rtl/zscan_bp_bank.sv
`timescale 1ns/1ps
module zscan_bp_bank import zscan_pkg::*; #(
  parameter int SIDE_LOG2 = 3,
  parameter int BP_W      = 8,
  localparam int CW     = 2 * SIDE_LOG2,
  localparam int LEVELS = SIDE_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active_i,
  input  logic [CW-1:0]   idx_i,
  input  logic [BP_W-1:0] bp_i,
  output logic            load_o,
  output logic [BP_W-1:0] val_o
);

  logic [LEVELS-1:0] enter;
  logic [BP_W-1:0]   cand [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    // Level g+1 has blocks of 2^(g+1) pixels a side, quadrants of 2^g.
    localparam int SUBW = 2 * g;
    localparam logic [CW-1:0] SUB_MASK = CW'((64'd1 << SUBW) - 64'd1);
    localparam logic [CW-1:0] BOT_LEFT = CW'(alt_bits(SUBW, 0));
    localparam logic [CW-1:0] TOP_RIGHT = CW'(alt_bits(SUBW, 1));

    logic [1:0]      dig;
    logic [CW-1:0]   sub;
    logic [BP_W-1:0] slot_a, slot_b;
    logic            cap_a, cap_b;

    assign dig   = idx_i[2*g+1 -: 2];
    assign sub   = idx_i & SUB_MASK;
    assign cap_a = active_i && (dig == 2'd0 || dig == 2'd2) && (sub == BOT_LEFT);
    assign cap_b = active_i && (dig == 2'd0) && (sub == TOP_RIGHT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_a <= '0;
        slot_b <= '0;
      end else begin
        if (cap_a) slot_a <= bp_i;
        if (cap_b) slot_b <= bp_i;
      end
    end

    assign enter[g] = (sub == '0) && (dig != 2'd0);
    assign cand[g]  = (dig == 2'd2) ? slot_b : slot_a;
  end

  // Later (larger) levels overwrite earlier ones.
  always_comb begin
    load_o = 1'b0;
    val_o  = '0;
    for (int g = 0; g < LEVELS; g++) begin
      if (active_i && enter[g]) begin
        load_o = 1'b1;
        val_o  = cand[g];
      end
    end
  end

endmodule

// File: rtl/zscan_bp_handoff.sv
`timescale 1ns/1ps
module zscan_bp_handoff import zscan_pkg::*; #(
  parameter int SIDE_LOG2 = 3,
  parameter int BP_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic [BP_W-1:0]      bp_i,
  output logic                 addr_valid_o,
  output logic                 addr_last_o,
  output logic [SIDE_LOG2-1:0] row_o,
  output logic [SIDE_LOG2-1:0] col_o,
  output logic                 bp_load_o,
  output logic [BP_W-1:0]      bp_val_o
);

  localparam int CW = 2 * SIDE_LOG2;

  logic          busy;
  logic          last;
  logic [CW-1:0] idx;
  scan_mode_e    scan_mode;
  logic          z_active;

  zscan_seq #(.SIDE_LOG2(SIDE_LOG2)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .busy_o  (busy),
    .last_o  (last),
    .idx_o   (idx),
    .mode_o  (scan_mode)
  );

  zscan_addr_map #(.SIDE_LOG2(SIDE_LOG2)) u_map (
    .idx_i  (idx),
    .mode_i (scan_mode),
    .row_o  (row_o),
    .col_o  (col_o)
  );

  assign z_active = busy && (scan_mode == SCAN_Z);

  zscan_bp_bank #(.SIDE_LOG2(SIDE_LOG2), .BP_W(BP_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (z_active),
    .idx_i    (idx),
    .bp_i     (bp_i),
    .load_o   (bp_load_o),
    .val_o    (bp_val_o)
  );

  assign addr_valid_o = busy;
  assign addr_last_o  = last;

endmodule

// File: rtl/zscan_bp_handoff_chk.sv
`timescale 1ns/1ps
module zscan_bp_handoff_chk import zscan_pkg::*; #(
  parameter int SIDE_LOG2 = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 addr_valid_o,
  input logic                 addr_last_o,
  input logic [SIDE_LOG2-1:0] row_o,
  input logic [SIDE_LOG2-1:0] col_o,
  input logic                 bp_load_o,
  input scan_mode_e           scan_mode
);

  localparam int CW = 2 * SIDE_LOG2;
  logic [CW-1:0] rc;
  assign rc = {row_o, col_o};

  a_r2_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !addr_last_o |=> addr_valid_o);

  a_r2_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last_o |=> !addr_valid_o);

  a_r5_raster_step: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !addr_last_o && scan_mode == SCAN_RASTER
    |=> rc == CW'($past(rc) + 1'b1));

  a_r12_no_load_raster: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == SCAN_RASTER || !addr_valid_o) |-> !bp_load_o);

  a_r11_no_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !$past(addr_valid_o) |-> !bp_load_o);

  a_r11_load_each_z: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && $past(addr_valid_o) && scan_mode == SCAN_Z |-> bp_load_o);

endmodule

bind zscan_bp_handoff zscan_bp_handoff_chk #(.SIDE_LOG2(SIDE_LOG2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid_o (addr_valid_o),
  .addr_last_o  (addr_last_o),
  .row_o        (row_o),
  .col_o        (col_o),
  .bp_load_o    (bp_load_o),
  .scan_mode    (scan_mode)
);

// File: tb/zscan_bp_handoff_tb.sv
`timescale 1ns/1ps
module zscan_bp_handoff_tb;
  localparam int N    = 3;
  localparam int BW   = 8;
  localparam int SIDE = 1 << N;
  localparam int NPIX = SIDE * SIDE;

  logic          clk = 1'b0;
  logic          rst_n, start_i, mode_i;
  logic [BW-1:0] bp_i;
  logic          addr_valid_o, addr_last_o, bp_load_o;
  logic [N-1:0]  row_o, col_o;
  logic [BW-1:0] bp_val_o;

  always #5 clk = ~clk;

  zscan_bp_handoff #(.SIDE_LOG2(N), .BP_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .bp_i(bp_i),
    .addr_valid_o(addr_valid_o), .addr_last_o(addr_last_o),
    .row_o(row_o), .col_o(col_o), .bp_load_o(bp_load_o), .bp_val_o(bp_val_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state
  bit mbusy = 1'b0;
  int midx  = 0;
  int mmode = 0;
  int er, ec;
  int frame_len = 0;
  bit saw_mid_start = 1'b0;
  int bpmem [SIDE][SIDE];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int d, lvl, nr, nc;
    bit eload;
    chk(addr_valid_o == mbusy, "R2 valid", int'(addr_valid_o), int'(mbusy));
    if (!mbusy) begin
      chk(!bp_load_o, "R1 R12 idle load", int'(bp_load_o), 0);
      return;
    end
    if (mmode == 0) begin
      er = 0; ec = 0;
      for (int j = 0; j < N; j++) begin
        er |= ((midx >> (2*j)) & 1) << j;
        ec |= ((midx >> (2*j+1)) & 1) << j;
      end
    end else begin
      er = midx / SIDE;
      ec = midx % SIDE;
    end
    chk(int'(row_o) == er, (mmode == 0) ? "R4 R6 row" : "R5 R6 row", int'(row_o), er);
    chk(int'(col_o) == ec, (mmode == 0) ? "R4 R6 col" : "R5 R6 col", int'(col_o), ec);
    chk(addr_last_o == (midx == NPIX-1), "R2 last", int'(addr_last_o), int'(midx == NPIX-1));
    eload = 1'b0; d = 0; lvl = 0;
    if (mmode == 0 && midx != 0) begin
      for (int j = 0; j < N; j++) begin
        if (lvl == 0 && ((midx >> (2*j)) & 3) != 0) begin
          d = (midx >> (2*j)) & 3;
          lvl = j + 1;
        end
      end
      eload = 1'b1;
    end
    if (mmode != 0) chk(!bp_load_o, "R12 raster load", int'(bp_load_o), 0);
    else if (midx == 0) chk(!bp_load_o, "R11 first pixel load", int'(bp_load_o), 0);
    else chk(bp_load_o == eload, "R8 R11 load flag", int'(bp_load_o), int'(eload));
    if (eload) begin
      // Neighbour: left for quadrant 2, above for quadrants 1 and 3.
      nr = (d == 2) ? er : er - 1;
      nc = (d == 2) ? ec - 1 : ec;
      case (d)
        1: chk(int'(bp_val_o) == bpmem[nr][nc], (lvl > 1) ? "R7 R8 R11 value" : "R7 R8 value",
               int'(bp_val_o), bpmem[nr][nc]);
        2: chk(int'(bp_val_o) == bpmem[nr][nc], (lvl > 1) ? "R7 R9 R11 value" : "R7 R9 value",
               int'(bp_val_o), bpmem[nr][nc]);
        default: chk(int'(bp_val_o) == bpmem[nr][nc], (lvl > 1) ? "R7 R10 R11 value" : "R7 R10 value",
               int'(bp_val_o), bpmem[nr][nc]);
      endcase
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; bp_i = '0;
    repeat (3) @(negedge clk);
    chk(!addr_valid_o, "R1 valid in reset", int'(addr_valid_o), 0);
    chk(!addr_last_o, "R1 last in reset", int'(addr_last_o), 0);
    chk(!bp_load_o, "R1 load in reset", int'(bp_load_o), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      compare();
      if (mbusy) begin
        frame_len++;
        if (midx == NPIX-1) begin
          chk(frame_len == NPIX, saw_mid_start ? "R2 R3 frame length" : "R2 frame length",
              frame_len, NPIX);
          frame_len = 0;
          saw_mid_start = 1'b0;
        end
      end
      // Stimulus for the coming edge.
      start_i = (cyc == 2) || (cyc == 20) || (cyc == 100) || (cyc >= 180 && cyc < 330);
      mode_i  = (cyc >= 30 && cyc < 40) || (cyc >= 100 && cyc < 180) || (cyc >= 230);
      if (mbusy && start_i) saw_mid_start = 1'b1;  // R3 pulse during a frame
      bp_i = BW'(cyc * 37 + 11);
      if (mbusy) bpmem[er][ec] = int'(bp_i);
      // Advance the reference to the next cycle.
      if (!mbusy && start_i) begin
        mbusy = 1'b1; midx = 0; mmode = int'(mode_i);
      end else if (mbusy) begin
        if (midx == NPIX-1) mbusy = 1'b0;
        else midx++;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule